// File: doc/BRIEF.md
# Anti-Shock Buffer Write Sequencer

This block governs the write side of an audio ring buffer kept in external memory for a disc player that must ride out mechanical shocks. Audio arrives faster than it is played, so the buffer fills. Once it is full, the writer stops and the host searches the disc for its last position. When a shock is reported, writing stops at once, because the incoming data can no longer be trusted. When the host reports that the position has been found again, the write pointer is rewound to the last subcode-frame checkpoint, and new audio joins exactly where good audio ended.

The sequencer has eight states. Each has a 3-bit code on `state_o`:

| Code | State | Meaning |
|------|-------|---------|
| 0 | idle | pointers cleared, waiting to write the first nibble |
| 1 | fill-start | filling, no checkpoint taken yet |
| 2 | fill-run | filling with a checkpoint held |
| 3 | fill-splice | filling after a restore |
| 4 | hold-splice | pointer restored, waiting to write the first nibble |
| 5 | hold-seek | shock over, host searching |
| 6 | hold-full | buffer full, host searching |
| 7 | shock | shock in progress |

Transitions:

- idle→fill-start on a written nibble.
- fill-start/fill-splice→fill-run on a frame pulse.
- Any fill state→hold-full on full, or →shock on shock.
- hold-splice→shock on shock, or →fill-splice on a written nibble.
- shock→hold-seek when shock drops; hold-seek→shock when it returns.
- hold-full, hold-seek or shock→hold-splice on position-found.
- hold-full, hold-seek or shock→idle on empty with echo low.
- Any state→idle on flush.

The pointer logic outside this block acts on three one-cycle strobes: save, restore and clear. The block itself does no pointer arithmetic.

Top module: `asb_write_seq`

## Requirements
- R1: While `rst_n` is low, `state_o` is 0, `fill_o` is 0, `clear_ptr_o` is 1, and `save_wp_o` and `restore_wp_o` are 0.
- R2: In idle, `fill_o` is 1. A high `nibble_done_i` moves the state to fill-start (1) one clock later.
- R3: In a fill state (1, 2 or 3), a pulse on either `frame_real_i` or `frame_synth_i` gives `save_wp_o`=1 for one cycle and the state fill-run (2) on the next clock, unless a shock, full or flush is taken in that cycle.
- R4: In a fill state, `buf_full_i` without shock moves the state to hold-full (6) with `fill_o`=0 on the next clock.
- R5: `shock_i` in a fill state, in hold-splice or in hold-seek moves the state to shock (7) with `fill_o`=0 and no save, and takes precedence over full and frame pulses. Shock dropping moves the state to hold-seek (5). `fill_o` is 0 in states 5, 6 and 7.
- R6: `pos_found_i` in hold-full, hold-seek or shock gives state hold-splice (4), `restore_wp_o`=1 for one cycle and `fill_o`=1. It takes precedence over shock. A following `nibble_done_i` gives fill-splice (3). `pos_found_i` in a fill state changes nothing.
- R7: `flush_i` in any state gives state idle (0), `clear_ptr_o`=1 for one cycle and `fill_o`=1, and takes precedence over every other input.
- R8: `buf_empty_i` with `echo_i` low in hold-full, hold-seek or shock gives state idle with `clear_ptr_o`=1.
- R9: `buf_empty_i` with `echo_i` high leaves a hold or shock state unchanged, with no clear strobe.
- R10: All outputs are registered and change on the clock edge that samples their cause. The state register may be one-hot or binary (parameter `ONE_HOT`), with identical port behaviour.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | system clock |
| rst_n | input | 1 | asynchronous reset, active low |
| flush_i | input | 1 | flush command pulse |
| pos_found_i | input | 1 | host has found its disc position again |
| shock_i | input | 1 | shock flag from the shock processor |
| echo_i | input | 1 | replay buffer contents when empty instead of restarting |
| nibble_done_i | input | 1 | first data nibble written to memory |
| frame_real_i | input | 1 | decoded subcode frame pulse |
| frame_synth_i | input | 1 | synthesised subcode frame pulse |
| buf_full_i | input | 1 | buffer full indication |
| buf_empty_i | input | 1 | buffer empty indication |
| fill_o | output | 1 | write enable for the buffer |
| state_o | output | 3 | current state code |
| save_wp_o | output | 1 | checkpoint the write pointer |
| restore_wp_o | output | 1 | rewind the write pointer to the checkpoint |
| clear_ptr_o | output | 1 | clear read and write pointers |

## Verification
The bench builds the block twice, with `ONE_HOT`=1 and `ONE_HOT`=0, drives both copies with the same inputs and expects the same results from each. This puts both register variants and their decode within reach of every directed check. The scenarios cover the following:
- the full-hold-splice round trip;
- shock entry, release and re-entry;
- both empty behaviours, with echo high and echo low;
- the priority of flush over position-found, and of position-found over shock.

// File: rtl/asb_pkg.sv
package asb_pkg;
    localparam int AS_NUM = 8;
    localparam int AS_W   = $clog2(AS_NUM);

    typedef enum logic [AS_W-1:0] {
        AS_IDLE        = 3'd0,
        AS_FILL_START  = 3'd1,
        AS_FILL_RUN    = 3'd2,
        AS_FILL_SPLICE = 3'd3,
        AS_HOLD_SPLICE = 3'd4,
        AS_HOLD_SEEK   = 3'd5,
        AS_HOLD_FULL   = 3'd6,
        AS_SHOCK       = 3'd7
    } asb_state_e;

    function automatic logic as_writing(input asb_state_e s);
        return (s == AS_IDLE) || (s == AS_FILL_START) || (s == AS_FILL_RUN) ||
               (s == AS_FILL_SPLICE) || (s == AS_HOLD_SPLICE);
    endfunction

    function automatic logic as_waiting(input asb_state_e s);
        return (s == AS_HOLD_FULL) || (s == AS_HOLD_SEEK) || (s == AS_SHOCK);
    endfunction
endpackage

// File: rtl/asb_next.sv
module asb_next
    import asb_pkg::*;
(
    input  asb_state_e cur,
    input  logic       flush,
    input  logic       pos_found,
    input  logic       shock,
    input  logic       echo,
    input  logic       nibble_done,
    input  logic       frame,
    input  logic       full,
    input  logic       empty,
    output asb_state_e nxt,
    output logic       save,
    output logic       restore,
    output logic       clear
);
    logic drop_empty;

    always_comb begin
        nxt        = cur;
        save       = 1'b0;
        restore    = 1'b0;
        clear      = 1'b0;
        drop_empty = empty && !echo;
        if (flush) begin
            nxt   = AS_IDLE;
            clear = 1'b1;
        end else if (pos_found && as_waiting(cur)) begin
            nxt     = AS_HOLD_SPLICE;
            restore = 1'b1;
        end else begin
            unique case (cur)
                AS_IDLE: begin
                    if (nibble_done) nxt = AS_FILL_START;
                end
                AS_FILL_START, AS_FILL_RUN, AS_FILL_SPLICE: begin
                    if (shock) begin
                        nxt = AS_SHOCK;
                    end else if (full) begin
                        nxt = AS_HOLD_FULL;
                    end else if (frame) begin
                        nxt  = AS_FILL_RUN;
                        save = 1'b1;
                    end
                end
                AS_HOLD_SPLICE: begin
                    if (shock)            nxt = AS_SHOCK;
                    else if (nibble_done) nxt = AS_FILL_SPLICE;
                end
                AS_HOLD_FULL: begin
                    if (drop_empty) begin
                        nxt   = AS_IDLE;
                        clear = 1'b1;
                    end
                end
                AS_HOLD_SEEK: begin
                    if (drop_empty) begin
                        nxt   = AS_IDLE;
                        clear = 1'b1;
                    end else if (shock) begin
                        nxt = AS_SHOCK;
                    end
                end
                AS_SHOCK: begin
                    if (drop_empty) begin
                        nxt   = AS_IDLE;
                        clear = 1'b1;
                    end else if (!shock) begin
                        nxt = AS_HOLD_SEEK;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/asb_state_reg.sv
module asb_state_reg
    import asb_pkg::*;
#(
    parameter bit ONE_HOT = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  asb_state_e nxt,
    output asb_state_e cur
);
    generate
        if (ONE_HOT) begin : g_onehot
            logic [AS_NUM-1:0] oh_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    oh_q <= AS_NUM'(1);
                end else begin
                    oh_q      <= '0;
                    oh_q[nxt] <= 1'b1;
                end
            end
            always_comb begin
                cur = AS_IDLE;
                for (int i = 0; i < AS_NUM; i++) begin
                    if (oh_q[i]) cur = asb_state_e'(AS_W'(i));
                end
            end
        end else begin : g_binary
            asb_state_e bin_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) bin_q <= AS_IDLE;
                else        bin_q <= nxt;
            end
            assign cur = bin_q;
        end
    endgenerate
endmodule

// File: rtl/asb_out_reg.sv
module asb_out_reg
    import asb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  asb_state_e nxt,
    input  logic       save,
    input  logic       restore,
    input  logic       clear,
    output logic       fill_q,
    output logic       save_q,
    output logic       restore_q,
    output logic       clear_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fill_q    <= 1'b0;
            save_q    <= 1'b0;
            restore_q <= 1'b0;
            clear_q   <= 1'b1;
        end else begin
            fill_q    <= as_writing(nxt);
            save_q    <= save;
            restore_q <= restore;
            clear_q   <= clear;
        end
    end
endmodule

// File: rtl/asb_write_seq.sv
module asb_write_seq
    import asb_pkg::*;
#(
    parameter bit ONE_HOT = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flush_i,
    input  logic            pos_found_i,
    input  logic            shock_i,
    input  logic            echo_i,
    input  logic            nibble_done_i,
    input  logic            frame_real_i,
    input  logic            frame_synth_i,
    input  logic            buf_full_i,
    input  logic            buf_empty_i,
    output logic            fill_o,
    output logic [AS_W-1:0] state_o,
    output logic            save_wp_o,
    output logic            restore_wp_o,
    output logic            clear_ptr_o
);
    asb_state_e cur, nxt;
    logic       save, restore, clear;

    asb_next u_next (
        .cur         (cur),
        .flush       (flush_i),
        .pos_found   (pos_found_i),
        .shock       (shock_i),
        .echo        (echo_i),
        .nibble_done (nibble_done_i),
        .frame       (frame_real_i || frame_synth_i),
        .full        (buf_full_i),
        .empty       (buf_empty_i),
        .nxt         (nxt),
        .save        (save),
        .restore     (restore),
        .clear       (clear)
    );

    asb_state_reg #(.ONE_HOT(ONE_HOT)) u_state (
        .clk   (clk),
        .rst_n (rst_n),
        .nxt   (nxt),
        .cur   (cur)
    );

    asb_out_reg u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .nxt       (nxt),
        .save      (save),
        .restore   (restore),
        .clear     (clear),
        .fill_q    (fill_o),
        .save_q    (save_wp_o),
        .restore_q (restore_wp_o),
        .clear_q   (clear_ptr_o)
    );

    assign state_o = cur;
endmodule

// File: rtl/asb_write_seq_chk.sv
module asb_write_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       flush_i,
    input logic       pos_found_i,
    input logic       shock_i,
    input logic       echo_i,
    input logic       frame_real_i,
    input logic       frame_synth_i,
    input logic       buf_full_i,
    input logic       buf_empty_i,
    input logic       fill_o,
    input logic [2:0] state_o,
    input logic       save_wp_o,
    input logic       restore_wp_o,
    input logic       clear_ptr_o
);
    logic waiting, filling;
    assign waiting = (state_o == 3'd5) || (state_o == 3'd6) || (state_o == 3'd7);
    assign filling = (state_o == 3'd1) || (state_o == 3'd2) || (state_o == 3'd3);

    // R7
    flush_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (state_o == 3'd0) && clear_ptr_o && fill_o);

    // R6
    restore_ctx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restore_wp_o |-> (state_o == 3'd4) && fill_o && $past(pos_found_i));

    // R3
    save_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        save_wp_o |-> (state_o == 3'd2) && $past(frame_real_i || frame_synth_i));

    // R4
    full_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (filling && buf_full_i && !shock_i && !flush_i) |=> (state_o == 3'd6) && !fill_o);

    // R5
    hold_nofill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        waiting |-> !fill_o);

    // R8
    empty_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (waiting && buf_empty_i && !echo_i && !flush_i && !pos_found_i)
        |=> (state_o == 3'd0) && clear_ptr_o);

    // R9
    echo_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_o == 3'd6) && buf_empty_i && echo_i && !flush_i && !pos_found_i)
        |=> (state_o == 3'd6) && !clear_ptr_o);

    // R10
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({save_wp_o, restore_wp_o, clear_ptr_o}));
endmodule

bind asb_write_seq asb_write_seq_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .flush_i       (flush_i),
    .pos_found_i   (pos_found_i),
    .shock_i       (shock_i),
    .echo_i        (echo_i),
    .frame_real_i  (frame_real_i),
    .frame_synth_i (frame_synth_i),
    .buf_full_i    (buf_full_i),
    .buf_empty_i   (buf_empty_i),
    .fill_o        (fill_o),
    .state_o       (state_o),
    .save_wp_o     (save_wp_o),
    .restore_wp_o  (restore_wp_o),
    .clear_ptr_o   (clear_ptr_o)
);

// File: tb/asb_write_seq_test.sv
`timescale 1ns/1ps
module asb_write_seq_test;
    logic clk = 1'b0;
    logic rst_n;
    logic flush, pos, shock, echo, nib, fr_real, fr_syn, full, empty;
    logic       fill_a, save_a, rest_a, clr_a;
    logic [2:0] st_a;
    logic       fill_b, save_b, rest_b, clr_b;
    logic [2:0] st_b;
    int checks = 0;
    int bad    = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    asb_write_seq #(.ONE_HOT(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .flush_i(flush), .pos_found_i(pos), .shock_i(shock),
        .echo_i(echo), .nibble_done_i(nib), .frame_real_i(fr_real), .frame_synth_i(fr_syn),
        .buf_full_i(full), .buf_empty_i(empty), .fill_o(fill_a), .state_o(st_a),
        .save_wp_o(save_a), .restore_wp_o(rest_a), .clear_ptr_o(clr_a));

    asb_write_seq #(.ONE_HOT(1'b0)) uut_bin (
        .clk(clk), .rst_n(rst_n), .flush_i(flush), .pos_found_i(pos), .shock_i(shock),
        .echo_i(echo), .nibble_done_i(nib), .frame_real_i(fr_real), .frame_synth_i(fr_syn),
        .buf_full_i(full), .buf_empty_i(empty), .fill_o(fill_b), .state_o(st_b),
        .save_wp_o(save_b), .restore_wp_o(rest_b), .clear_ptr_o(clr_b));

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic idle_inputs();
        flush = 0; pos = 0; shock = 0; echo = 0; nib = 0;
        fr_real = 0; fr_syn = 0; full = 0; empty = 0;
    endtask

    // expected vector: {state, fill, save, restore, clear}
    task automatic expect_out(input string tag, input logic [2:0] st,
                              input logic fl, input logic sv, input logic rs, input logic cl);
        logic [6:0] exp_v, act_a, act_b;
        exp_v = {st, fl, sv, rs, cl};
        act_a = {st_a, fill_a, save_a, rest_a, clr_a};
        act_b = {st_b, fill_b, save_b, rest_b, clr_b};
        checks++;
        if (act_a !== exp_v || act_b !== exp_v) begin
            bad++;
            $display("FAIL %s actual onehot=%h binary=%h expected=%h", tag, act_a, act_b, exp_v);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0; idle_inputs();
        tick();
        expect_out("R1 reset outputs", 3'd0, 0, 0, 0, 1);
        fr_syn = 1; pos = 1; tick();
        expect_out("R1 reset ignores inputs", 3'd0, 0, 0, 0, 1);
        idle_inputs(); rst_n = 1'b1;
        tick();
        expect_out("R2 idle fills", 3'd0, 1, 0, 0, 0);
    endtask

    task automatic t_fill_and_save();
        nib = 1; tick(); nib = 0;
        expect_out("R2 first nibble", 3'd1, 1, 0, 0, 0);
        fr_syn = 1; tick(); fr_syn = 0;
        expect_out("R3 synth frame save", 3'd2, 1, 1, 0, 0);
        tick();
        expect_out("R3 save one cycle R10", 3'd2, 1, 0, 0, 0);
        fr_real = 1; tick(); fr_real = 0;
        expect_out("R3 real frame save", 3'd2, 1, 1, 0, 0);
        pos = 1; tick(); pos = 0;
        expect_out("R6 pos_found ignored in fill", 3'd2, 1, 0, 0, 0);
        full = 1; tick(); full = 0;
        expect_out("R4 full to hold", 3'd6, 0, 0, 0, 0);
    endtask

    task automatic t_empty_echo();
        echo = 1; empty = 1; tick();
        expect_out("R9 echo keeps hold", 3'd6, 0, 0, 0, 0);
        echo = 0; tick(); empty = 0;
        expect_out("R8 empty restarts", 3'd0, 1, 0, 0, 1);
    endtask

    task automatic t_splice();
        nib = 1; tick(); nib = 0;
        fr_real = 1; tick(); fr_real = 0;
        full = 1; tick(); full = 0;
        expect_out("R4 hold again", 3'd6, 0, 0, 0, 0);
        pos = 1; tick(); pos = 0;
        expect_out("R6 restore on pos_found", 3'd4, 1, 0, 1, 0);
        nib = 1; tick(); nib = 0;
        expect_out("R6 resume fill-splice", 3'd3, 1, 0, 0, 0);
        fr_syn = 1; tick(); fr_syn = 0;
        expect_out("R3 save after splice", 3'd2, 1, 1, 0, 0);
    endtask

    task automatic t_shock();
        shock = 1; full = 1; fr_real = 1; tick(); full = 0; fr_real = 0;
        expect_out("R5 shock beats full and frame", 3'd7, 0, 0, 0, 0);
        tick();
        expect_out("R5 shock held", 3'd7, 0, 0, 0, 0);
        shock = 0; tick();
        expect_out("R5 release to seek", 3'd5, 0, 0, 0, 0);
        shock = 1; tick(); shock = 0;
        expect_out("R5 re-shock from seek", 3'd7, 0, 0, 0, 0);
        tick();
        echo = 1; empty = 1; tick(); echo = 0; empty = 0;
        expect_out("R9 echo keeps seek", 3'd5, 0, 0, 0, 0);
        pos = 1; flush = 1; tick(); pos = 0; flush = 0;
        expect_out("R7 flush beats pos_found", 3'd0, 1, 0, 0, 1);
    endtask

    task automatic t_priority();
        nib = 1; tick(); nib = 0;
        shock = 1; tick();
        expect_out("R5 shock from fill-start", 3'd7, 0, 0, 0, 0);
        pos = 1; tick(); pos = 0;
        expect_out("R6 pos_found beats shock", 3'd4, 1, 0, 1, 0);
        tick();
        expect_out("R5 shock in hold-splice", 3'd7, 0, 0, 0, 0);
        shock = 0; empty = 1; tick(); empty = 0;
        expect_out("R8 empty in shock", 3'd0, 1, 0, 0, 1);
        nib = 1; tick(); nib = 0;
        flush = 1; tick(); flush = 0;
        expect_out("R7 flush from fill", 3'd0, 1, 0, 0, 1);
        tick();
        expect_out("R7 clear one cycle", 3'd0, 1, 0, 0, 0);
    endtask

    initial begin
        t_reset();
        t_fill_and_save();
        t_empty_echo();
        t_splice();
        t_shock();
        t_priority();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end
endmodule